// File: doc/BRIEF.md
# Rotate, Shift and Digit-Rotate Unit

This block is the bit-movement stage of an 8-bit datapath. In one cycle it moves the bits of a byte: it rotates through the carry, rotates circularly, and shifts left or right in arithmetic or logical form. It also rotates packed decimal digits between the accumulator and a memory byte. The caller supplies an operation code, the operand byte, the accumulator, a carry input and the current flag byte. The unit returns the result byte, which is the value written back to a register or to memory. It also returns the new accumulator and the new flag byte.

The operation is computed by combinational logic and captured in one output register stage. Each output is therefore valid one clock edge after its inputs were sampled. Three flag policies exist. The general forms rebuild the sign, zero and parity flags from the result. The accumulator-only rotates keep those three flags and change only the carry and the two arithmetic flags. The digit rotates keep the carry and rebuild the other flags from the new accumulator. The flag byte layout is fixed: sign in bit 7, zero in bit 6, half carry in bit 4, parity/overflow in bit 2, subtract in bit 1 and carry in bit 0. Bits 5 and 3 pass through from the input flag byte.

Top module: `rsu_top`

## Requirements
- R1: Codes 0 (left) and 1 (right) rotate the operand through the carry as a 9-bit ring. Left: bit 7 goes to carry and carry_in goes to bit 0. Right: bit 0 goes to carry and carry_in goes to bit 7.
- R2: Codes 2 (left) and 3 (right) rotate the operand circularly. The bit that leaves one end enters the other end and is also copied to the carry.
- R3: Code 4 doubles the operand. Bit 7 goes to carry and 0 enters bit 0.
- R4: Code 5 shifts right arithmetically. Bit 7 keeps its value and bit 0 goes to carry.
- R5: Code 6 shifts right logically. 0 enters bit 7 and bit 0 goes to carry.
- R6: For codes 0 to 6, the new flags are: bit 7 = result bit 7; bit 6 = 1 when the result is zero; bits 4 and 1 = 0; bit 2 = 1 when the result has an even number of ones; bit 0 = the carry out. Bits 5 and 3 are copied from flags_in, and acc_out equals acc_in.
- R7: Codes 7, 8, 9 and 10 apply the operations of codes 0, 1, 2 and 3 to acc_in instead of the operand. The result goes to both result and acc_out. Flag bits 7, 6 and 2 are copied from flags_in, bits 4 and 1 are cleared, and bit 0 is the carry out.
- R8: Code 11 (digit left) sets acc_out to {acc_in[7:4], operand[7:4]} and result to {operand[3:0], acc_in[3:0]}.
- R9: Code 12 (digit right) sets acc_out to {acc_in[7:4], operand[3:0]} and result to {acc_in[3:0], operand[7:4]}.
- R10: For codes 11 and 12, carry_in has no effect and flag bit 0 equals flags_in bit 0. Bits 7, 6 and 2 follow the sign, zero and even parity of acc_out, and bits 4 and 1 are cleared.
- R11: Codes 13 to 15 change nothing: result equals the operand, acc_out equals acc_in and flags_out equals flags_in.
- R12: Outputs are registered: they reflect the inputs sampled at the previous rising edge. While rst_n is low at an edge, result, acc_out and flags_out become zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_sel | input | 4 | Operation code, 0 to 15 |
| operand | input | W | Operand byte (register or memory value) |
| acc_in | input | W | Current accumulator |
| carry_in | input | 1 | Carry fed into the through-carry rotates |
| flags_in | input | 8 | Current flag byte |
| result | output | W | Result byte to write back |
| acc_out | output | W | New accumulator |
| flags_out | output | 8 | New flag byte |

## Verification
The bench builds the unit with the default width W=8. At that width every operation code can be driven with all 256 operand values under both carry inputs. Every flag policy, every parity outcome and both end bits of each ring are covered completely instead of by sampling. Random accumulator and flag bytes during that sweep check that the fields which must be preserved really are preserved. Directed cases cover the zero operand, the all-ones operand and carry_in toggling during the digit rotates.

// File: rtl/rsu_pkg.sv
// Package rsu_pkg
// Shared operation codes, shift kinds, flag policies and flag bit
// positions for the rotate/shift unit. The flag positions are fixed
// because the flag byte is decoded by neighbouring logic.
package rsu_pkg;

    typedef enum logic [3:0] {
        OP_RL_THRU   = 4'd0,
        OP_RR_THRU   = 4'd1,
        OP_RL_CIRC   = 4'd2,
        OP_RR_CIRC   = 4'd3,
        OP_SL_ARITH  = 4'd4,
        OP_SR_ARITH  = 4'd5,
        OP_SR_LOGIC  = 4'd6,
        OP_ARL_THRU  = 4'd7,
        OP_ARR_THRU  = 4'd8,
        OP_ARL_CIRC  = 4'd9,
        OP_ARR_CIRC  = 4'd10,
        OP_DIG_LEFT  = 4'd11,
        OP_DIG_RIGHT = 4'd12,
        OP_RSV13     = 4'd13,
        OP_RSV14     = 4'd14,
        OP_RSV15     = 4'd15
    } rsu_op_e;

    typedef enum logic [1:0] {
        SK_THRU  = 2'd0,
        SK_CIRC  = 2'd1,
        SK_ARITH = 2'd2,
        SK_LOGIC = 2'd3
    } shift_kind_e;

    typedef enum logic [1:0] {
        FM_FULL  = 2'd0,
        FM_ACC   = 2'd1,
        FM_DIGIT = 2'd2,
        FM_HOLD  = 2'd3
    } flag_mode_e;

    localparam int FLAG_W  = 8;
    localparam int FB_SIGN = 7;
    localparam int FB_ZERO = 6;
    localparam int FB_HALF = 4;
    localparam int FB_PAR  = 2;
    localparam int FB_SUB  = 1;
    localparam int FB_CARRY = 0;

endpackage

// File: rtl/rsu_ring_shift.sv
// Module rsu_ring_shift
// Moves a word one place left or right. The kind selects what enters
// the vacated end: the carry input (through-carry), the bit that left
// (circular), a copy of the old top bit (arithmetic right; zero on the
// left) or zero (logical). The bit that leaves is always the carry out.
// Assumes W >= 2. Purely combinational.
module rsu_ring_shift
    import rsu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] src,
    input  logic         cin,
    input  logic         dir_left,
    input  shift_kind_e  kind,
    output logic [W-1:0] dst,
    output logic         cout
);

    logic fill_lo;
    logic fill_hi;

    // Choose the bit that enters the vacated end for each direction.
    always_comb begin
        unique case (kind)
            SK_THRU: begin
                fill_lo = cin;
                fill_hi = cin;
            end
            SK_CIRC: begin
                fill_lo = src[W-1];
                fill_hi = src[0];
            end
            SK_ARITH: begin
                fill_lo = 1'b0;
                fill_hi = src[W-1];
            end
            default: begin
                fill_lo = 1'b0;
                fill_hi = 1'b0;
            end
        endcase
    end

    // Assemble the moved word and the departing bit.
    always_comb begin
        if (dir_left) begin
            dst  = {src[W-2:0], fill_lo};
            cout = src[W-1];
        end else begin
            dst  = {fill_hi, src[W-1:1]};
            cout = src[0];
        end
    end

endmodule

// File: rtl/rsu_digit_rot.sv
// Module rsu_digit_rot
// Rotates three half-width digits: the low half of the accumulator and
// both halves of the memory byte. The accumulator's upper half never
// moves. Assumes W is even. Purely combinational.
module rsu_digit_rot #(
    parameter int W = 8
) (
    input  logic [W-1:0] acc,
    input  logic [W-1:0] mem,
    input  logic         left,
    output logic [W-1:0] acc_new,
    output logic [W-1:0] mem_new
);

    localparam int HW = W / 2;

    logic [HW-1:0] a_lo;
    logic [HW-1:0] m_hi;
    logic [HW-1:0] m_lo;

    assign a_lo = acc[HW-1:0];
    assign m_hi = mem[W-1:HW];
    assign m_lo = mem[HW-1:0];

    // Route the three digits in the chosen direction.
    always_comb begin
        if (left) begin
            acc_new = {acc[W-1:HW], m_hi};
            mem_new = {m_lo, a_lo};
        end else begin
            acc_new = {acc[W-1:HW], m_lo};
            mem_new = {a_lo, m_hi};
        end
    end

endmodule

// File: rtl/rsu_flag_gen.sv
// Module rsu_flag_gen
// Builds the new flag byte under one of four policies: full rebuild,
// accumulator-rotate (keep sign/zero/parity), digit (keep carry), hold.
// Bits not named in rsu_pkg pass through from flags_in. Combinational.
module rsu_flag_gen
    import rsu_pkg::*;
#(
    parameter int W = 8
) (
    input  flag_mode_e        mode,
    input  logic [W-1:0]      val,
    input  logic              cout,
    input  logic [FLAG_W-1:0] flags_in,
    output logic [FLAG_W-1:0] flags_out
);

    logic val_sign;
    logic val_zero;
    logic val_even;

    // Derive sign, zero and even parity of the value in view.
    always_comb begin
        val_sign = val[W-1];
        val_zero = (val == '0);
        val_even = ~(^val);
    end

    // Merge the derived bits into the flag byte per policy.
    always_comb begin
        flags_out = flags_in;
        unique case (mode)
            FM_FULL: begin
                flags_out[FB_SIGN]  = val_sign;
                flags_out[FB_ZERO]  = val_zero;
                flags_out[FB_HALF]  = 1'b0;
                flags_out[FB_PAR]   = val_even;
                flags_out[FB_SUB]   = 1'b0;
                flags_out[FB_CARRY] = cout;
            end
            FM_ACC: begin
                flags_out[FB_HALF]  = 1'b0;
                flags_out[FB_SUB]   = 1'b0;
                flags_out[FB_CARRY] = cout;
            end
            FM_DIGIT: begin
                flags_out[FB_SIGN]  = val_sign;
                flags_out[FB_ZERO]  = val_zero;
                flags_out[FB_HALF]  = 1'b0;
                flags_out[FB_PAR]   = val_even;
                flags_out[FB_SUB]   = 1'b0;
            end
            default: begin
                flags_out = flags_in;
            end
        endcase
    end

endmodule

// File: rtl/rsu_top.sv
// Module rsu_top
// Rotate, shift and digit-rotate unit with one registered output stage.
// Decodes op_sel into a source choice, a direction, a shift kind and a
// flag policy, then registers result, accumulator and flags.
// Assumes W is even and at least 4; the flag byte is 8 bits wide.
module rsu_top
    import rsu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        op_sel,
    input  logic [W-1:0]      operand,
    input  logic [W-1:0]      acc_in,
    input  logic              carry_in,
    input  logic [FLAG_W-1:0] flags_in,
    output logic [W-1:0]      result,
    output logic [W-1:0]      acc_out,
    output logic [FLAG_W-1:0] flags_out
);

    rsu_op_e     op;
    logic        src_is_acc;
    logic        dir_left;
    shift_kind_e kind;
    flag_mode_e  fmode;
    logic        digit_op;
    logic        digit_left;
    logic        pass_op;

    logic [W-1:0]      sh_src;
    logic [W-1:0]      sh_res;
    logic              sh_cout;
    logic [W-1:0]      dg_acc;
    logic [W-1:0]      dg_mem;
    logic [W-1:0]      flag_val;
    logic [FLAG_W-1:0] nx_flags;
    logic [W-1:0]      nx_res;
    logic [W-1:0]      nx_acc;

    assign op = rsu_op_e'(op_sel);

    // Decode the operation code into datapath controls.
    always_comb begin
        src_is_acc = 1'b0;
        dir_left   = 1'b1;
        kind       = SK_THRU;
        fmode      = FM_FULL;
        digit_op   = 1'b0;
        digit_left = 1'b1;
        pass_op    = 1'b0;
        unique case (op)
            OP_RL_THRU:  kind = SK_THRU;
            OP_RR_THRU: begin
                kind     = SK_THRU;
                dir_left = 1'b0;
            end
            OP_RL_CIRC:  kind = SK_CIRC;
            OP_RR_CIRC: begin
                kind     = SK_CIRC;
                dir_left = 1'b0;
            end
            OP_SL_ARITH: kind = SK_ARITH;
            OP_SR_ARITH: begin
                kind     = SK_ARITH;
                dir_left = 1'b0;
            end
            OP_SR_LOGIC: begin
                kind     = SK_LOGIC;
                dir_left = 1'b0;
            end
            OP_ARL_THRU: begin
                src_is_acc = 1'b1;
                fmode      = FM_ACC;
            end
            OP_ARR_THRU: begin
                src_is_acc = 1'b1;
                dir_left   = 1'b0;
                fmode      = FM_ACC;
            end
            OP_ARL_CIRC: begin
                src_is_acc = 1'b1;
                kind       = SK_CIRC;
                fmode      = FM_ACC;
            end
            OP_ARR_CIRC: begin
                src_is_acc = 1'b1;
                kind       = SK_CIRC;
                dir_left   = 1'b0;
                fmode      = FM_ACC;
            end
            OP_DIG_LEFT: begin
                digit_op = 1'b1;
                fmode    = FM_DIGIT;
            end
            OP_DIG_RIGHT: begin
                digit_op   = 1'b1;
                digit_left = 1'b0;
                fmode      = FM_DIGIT;
            end
            default: begin
                pass_op = 1'b1;
                fmode   = FM_HOLD;
            end
        endcase
    end

    assign sh_src = src_is_acc ? acc_in : operand;

    rsu_ring_shift #(.W(W)) u_ring (
        .src      (sh_src),
        .cin      (carry_in),
        .dir_left (dir_left),
        .kind     (kind),
        .dst      (sh_res),
        .cout     (sh_cout)
    );

    rsu_digit_rot #(.W(W)) u_digit (
        .acc     (acc_in),
        .mem     (operand),
        .left    (digit_left),
        .acc_new (dg_acc),
        .mem_new (dg_mem)
    );

    assign flag_val = digit_op ? dg_acc : sh_res;

    rsu_flag_gen #(.W(W)) u_flags (
        .mode      (fmode),
        .val       (flag_val),
        .cout      (sh_cout),
        .flags_in  (flags_in),
        .flags_out (nx_flags)
    );

    // Select the next result and accumulator values.
    always_comb begin
        if (pass_op) begin
            nx_res = operand;
            nx_acc = acc_in;
        end else if (digit_op) begin
            nx_res = dg_mem;
            nx_acc = dg_acc;
        end else if (src_is_acc) begin
            nx_res = sh_res;
            nx_acc = sh_res;
        end else begin
            nx_res = sh_res;
            nx_acc = acc_in;
        end
    end

    // Output register stage with synchronous active-low clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result    <= '0;
            acc_out   <= '0;
            flags_out <= '0;
        end else begin
            result    <= nx_res;
            acc_out   <= nx_acc;
            flags_out <= nx_flags;
        end
    end

endmodule

// File: rtl/rsu_checker.sv
// Module rsu_checker
// Temporal properties of rsu_top, bound to every instance. Each one
// compares the registered outputs with inputs seen one edge earlier.
module rsu_checker
    import rsu_pkg::*;
#(
    parameter int W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [3:0]        op_sel,
    input logic [W-1:0]      operand,
    input logic [W-1:0]      acc_in,
    input logic              carry_in,
    input logic [FLAG_W-1:0] flags_in,
    input logic [W-1:0]      result,
    input logic [W-1:0]      acc_out,
    input logic [FLAG_W-1:0] flags_out
);

    localparam int HW = W / 2;

    p_thru_left_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op_sel) == 4'd0) |->
        (result[0] == $past(carry_in) && flags_out[FB_CARRY] == $past(operand[W-1])));

    p_circ_left_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op_sel) == 4'd2) |->
        (result[0] == $past(operand[W-1]) && flags_out[FB_CARRY] == $past(operand[W-1])));

    p_asr_keep_top_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op_sel) == 4'd5) |->
        (result[W-1] == $past(operand[W-1]) && flags_out[FB_CARRY] == $past(operand[0])));

    p_general_acc_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op_sel) <= 4'd6) |->
        (acc_out == $past(acc_in) && flags_out[FB_HALF] == 1'b0 && flags_out[FB_SUB] == 1'b0));

    p_acc_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op_sel) >= 4'd7 && $past(op_sel) <= 4'd10) |->
        (flags_out[FB_SIGN] == $past(flags_in[FB_SIGN]) &&
         flags_out[FB_ZERO] == $past(flags_in[FB_ZERO]) &&
         flags_out[FB_PAR]  == $past(flags_in[FB_PAR]) && acc_out == result));

    p_digit_carry_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && ($past(op_sel) == 4'd11 || $past(op_sel) == 4'd12)) |->
        (flags_out[FB_CARRY] == $past(flags_in[FB_CARRY]) &&
         acc_out[W-1:HW] == $past(acc_in[W-1:HW])));

    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op_sel) >= 4'd13) |->
        (result == $past(operand) && flags_out == $past(flags_in)));

endmodule

bind rsu_top rsu_checker #(.W(W)) u_rsu_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_sel    (op_sel),
    .operand   (operand),
    .acc_in    (acc_in),
    .carry_in  (carry_in),
    .flags_in  (flags_in),
    .result    (result),
    .acc_out   (acc_out),
    .flags_out (flags_out)
);

// File: tb/tb_rsu_top.sv
// Bench for rsu_top: exhaustive operand sweep per code and carry,
// seeded random vectors and directed corners, against bench functions.
module tb_rsu_top;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [3:0]   op_sel = '0;
    logic [W-1:0] operand = '0;
    logic [W-1:0] acc_in = '0;
    logic         carry_in = 1'b0;
    logic [7:0]   flags_in = '0;
    logic [W-1:0] result;
    logic [W-1:0] acc_out;
    logic [7:0]   flags_out;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    rsu_top #(.W(W)) dut (
        .clk(clk), .rst_n(rst_n), .op_sel(op_sel), .operand(operand),
        .acc_in(acc_in), .carry_in(carry_in), .flags_in(flags_in),
        .result(result), .acc_out(acc_out), .flags_out(flags_out)
    );

    // Expected {result, acc_out, flags_out} from the requirement text.
    function automatic logic [23:0] model(input logic [3:0] op, input logic [7:0] x,
                                          input logic [7:0] a, input logic c,
                                          input logic [7:0] f);
        logic [7:0] r, na, nf, src;
        logic co;
        src = (op >= 4'd7 && op <= 4'd10) ? a : x;
        r = x; na = a; nf = f; co = 1'b0;
        case (op)
            4'd0, 4'd7:  {co, r} = {src, c};
            4'd1, 4'd8:  {r, co} = {c, src};
            4'd2, 4'd9:  begin r = {src[6:0], src[7]}; co = src[7]; end
            4'd3, 4'd10: begin r = {src[0], src[7:1]}; co = src[0]; end
            4'd4: begin r = src << 1; co = src[7]; end
            4'd5: begin r = {src[7], src[7:1]}; co = src[0]; end
            4'd6: begin r = src >> 1; co = src[0]; end
            4'd11: begin na = {a[7:4], x[7:4]}; r = {x[3:0], a[3:0]}; end
            4'd12: begin na = {a[7:4], x[3:0]}; r = {a[3:0], x[7:4]}; end
            default: ;
        endcase
        if (op <= 4'd6) begin
            nf = {r[7], r == 8'h00, f[5], 1'b0, f[3], ~(^r), 1'b0, co};
        end else if (op <= 4'd10) begin
            na = r;
            nf = {f[7], f[6], f[5], 1'b0, f[3], f[2], 1'b0, co};
        end else if (op <= 4'd12) begin
            nf = {na[7], na == 8'h00, f[5], 1'b0, f[3], ~(^na), 1'b0, f[0]};
        end
        return {r, na, nf};
    endfunction

    function automatic string req_of(input logic [3:0] op);
        case (op)
            4'd0, 4'd1:   return "R1/R6";
            4'd2, 4'd3:   return "R2/R6";
            4'd4:         return "R3/R6";
            4'd5:         return "R4/R6";
            4'd6:         return "R5/R6";
            4'd7, 4'd8, 4'd9, 4'd10: return "R7";
            4'd11:        return "R8/R10";
            4'd12:        return "R9/R10";
            default:      return "R11";
        endcase
    endfunction

    // Apply one vector at a falling edge and check after the next rise (R12 latency).
    task automatic apply(input logic [3:0] op, input logic [7:0] x, input logic [7:0] a,
                         input logic c, input logic [7:0] f);
        logic [23:0] exp;
        @(negedge clk);
        op_sel = op; operand = x; acc_in = a; carry_in = c; flags_in = f;
        exp = model(op, x, a, c, f);
        @(posedge clk);
        #2;
        checks++;
        if ({result, acc_out, flags_out} !== exp) begin
            failures++;
            $display("FAIL %s op=%0d x=%h a=%h c=%b f=%h: actual=%h expected=%h",
                     req_of(op), op, x, a, c, f, {result, acc_out, flags_out}, exp);
        end
    endtask

    initial begin
        void'($urandom(32'd4711));
        // R12: reset clears outputs even with live inputs.
        op_sel = 4'd2; operand = 8'hA5; acc_in = 8'h3C; flags_in = 8'hFF;
        repeat (3) @(posedge clk);
        #2;
        checks++;
        if ({result, acc_out, flags_out} !== 24'h0) begin
            failures++;
            $display("FAIL R12 reset: actual=%h expected=000000", {result, acc_out, flags_out});
        end
        @(negedge clk);
        rst_n = 1'b1;

        // Exhaustive sweep: every code, both carries, all operands (R1..R11).
        for (int op = 0; op < 16; op++) begin
            for (int c = 0; c < 2; c++) begin
                for (int x = 0; x < 256; x++) begin
                    apply(4'(op), 8'(x), 8'($urandom), 1'(c), 8'($urandom));
                end
            end
        end

        // Directed corners: zero, all-ones, parity extremes.
        apply(4'd0, 8'h80, 8'h00, 1'b0, 8'h00);  // R1 carry out, zero result
        apply(4'd1, 8'h01, 8'h00, 1'b1, 8'h00);  // R1 right ring
        apply(4'd3, 8'hFF, 8'h00, 1'b0, 8'h00);  // R2 all ones
        apply(4'd4, 8'h80, 8'h12, 1'b1, 8'hFF);  // R3 carry_in ignored
        apply(4'd5, 8'h81, 8'h00, 1'b0, 8'h00);  // R4 sign kept
        apply(4'd6, 8'h01, 8'h00, 1'b1, 8'hFF);  // R5 zero result
        apply(4'd9, 8'h00, 8'h80, 1'b0, 8'hC4);  // R7 flags kept
        apply(4'd11, 8'h00, 8'hF0, 1'b1, 8'h01); // R8/R10 carry kept
        apply(4'd12, 8'h00, 8'h00, 1'b1, 8'h00); // R9/R10 carry_in ignored
        apply(4'd14, 8'h5A, 8'hA5, 1'b1, 8'h28); // R11 pass through

        // Seeded random mix.
        for (int i = 0; i < 2000; i++) begin
            apply(4'($urandom), 8'($urandom), 8'($urandom), 1'($urandom), 8'($urandom));
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog: an unfinished run counts as a failed check.
    initial begin
        #1500000;
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule